// File: doc/BRIEF.md
# Scatter-Gather Byte Mover with Lane Swizzle

This block moves a peripheral's pending bytes between system memory and a byte-stream port. The memory side is a chain of descriptors. For each one the block fetches a buffer address, a flags word that holds the byte count and an end-of-chain mark, and a link to the next descriptor. The block walks the chain one byte at a time until it has moved the requested number of bytes or until a descriptor marked as the last one runs dry.

Control is a set of static bits: an enable, a direction (host-to-device or device-to-host) and a byte order. Software sets these bits and a descriptor pointer. The peripheral then raises a request with the byte count it wants moved. Every data byte address is lane-remapped within its 32-bit word according to the byte order in force. The stream side marks the beat that closes each chunk of a fixed size. When the whole transfer ends, the block emits a one-cycle done pulse. After a host-to-device transfer it also emits a pulse that clears the peripheral's request.

Top module: `sgdma_byte_mover`

## Requirements
- R1: After reset, busy, done, dev_clear, mem_req_valid, dev_tx_valid and dev_rx_ready are all low.
- R2: A request starts a transfer only while idle, with ctl_en high and req_bytes nonzero. Any other request is ignored: no memory beat, and busy stays low.
- R3: A descriptor is fetched as 12 byte reads at desc_ptr+0 through +11, in ascending order and without remapping. Each 32-bit word is assembled most-significant byte first. Word 0 is the buffer address, word 1 the flags and word 2 the next-descriptor address.
- R4: The byte count of a descriptor is flags[13:0]. Each moved byte decrements it and advances the buffer address by one.
- R5: When a descriptor's count reaches zero, flags[31] is clear and requested bytes remain, the next-descriptor address is fetched before the next byte moves.
- R6: When a descriptor's count reaches zero with flags[31] set, the transfer ends even if requested bytes remain.
- R7: With ctl_be high, the memory address of a data byte has its two low bits XORed with 2'b11. With ctl_be low, the address is unchanged.
- R8: With ctl_h2d high, each data byte is read from memory and presented on dev_tx_data in chain order. A byte is held until dev_tx_ready accepts it.
- R9: With ctl_h2d low, each byte accepted from dev_rx_data is written to memory at the next chain address, with mem_req_we high.
- R10: dev_last is high on the stream beat that is byte CHUNK_BYTES-1 (mod CHUNK_BYTES) of the transfer, counting from zero, and on the final beat of the transfer.
- R11: done is high for exactly one cycle after the last byte, and busy is low on the following cycle.
- R12: dev_clear pulses together with done only for host-to-device transfers.
- R13: A memory request or tx beat that is not accepted keeps its valid high and its address or data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Transfer enable |
| ctl_h2d | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| ctl_be | input | 1 | 1 = big-endian lane remap |
| desc_ptr | input | ADDR_W | Address of the first descriptor |
| req_valid | input | 1 | Peripheral request strobe |
| req_bytes | input | REQ_W | Bytes the peripheral wants moved |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| dev_clear | output | 1 | Clears the peripheral request after host-to-device |
| mem_req_valid | output | 1 | Memory beat valid |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_we | output | 1 | 1 = write beat |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the accepting cycle |
| dev_tx_valid | output | 1 | Byte to the peripheral valid |
| dev_tx_ready | input | 1 | Peripheral takes the byte |
| dev_tx_data | output | 8 | Byte to the peripheral |
| dev_rx_valid | input | 1 | Byte from the peripheral valid |
| dev_rx_ready | output | 1 | Block takes the byte |
| dev_rx_data | input | 8 | Byte from the peripheral |
| dev_last | output | 1 | Stream beat closes a chunk or the transfer |

## Verification
The bench targets a chain hop in the middle of a request. A design that skips the refetch, or refetches from the wrong link, streams bytes from the old buffer past its count. An early end-of-chain mark with a larger request is the next case: a design that ignores flags[31] keeps walking and never matches the expected short stream. Big-endian runs use adjacent distinct byte values, so a missing or wrong XOR shows up as reordered bytes within each word. Chunk marks are checked across descriptor boundaries and on a final short chunk, and the request strobe is pulsed with the enable low and with a zero count to catch a block that starts anyway.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 12;
  localparam int CNT_W      = 14;
  localparam int EOC_BIT    = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_MRD, S_DTX, S_DRX, S_MWR, S_DONE
  } sgd_state_e;
endpackage

// File: rtl/sgd_desc_asm.sv
module sgd_desc_asm #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] buf_word,
  output logic [WORD_W-1:0] flag_word,
  output logic [WORD_W-1:0] link_word
);
  localparam int SR_W = 3 * WORD_W;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-9:0], din};
  end

  assign buf_word  = sr[SR_W-1 -: WORD_W];
  assign flag_word = sr[2*WORD_W-1 -: WORD_W];
  assign link_word = sr[WORD_W-1:0];
endmodule

// File: rtl/sgd_lane_swz.sv
module sgd_lane_swz #(
  parameter int ADDR_W = 32
) (
  input  logic              be,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  assign addr_out = {addr_in[ADDR_W-1:2], addr_in[1:0] ^ {2{be}}};
endmodule

// File: rtl/sgd_chunk_ctr.sv
module sgd_chunk_ctr #(
  parameter int CHUNK_BYTES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic at_last
);
  localparam int CW = (CHUNK_BYTES > 2) ? $clog2(CHUNK_BYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHUNK_BYTES - 1);
  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || clr) pos <= '0;
    else if (step) pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  assign at_last = (pos == LAST);
endmodule

// File: rtl/sgdma_byte_mover.sv
module sgdma_byte_mover
  import sgd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REQ_W       = 16,
  parameter int CHUNK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              ctl_h2d,
  input  logic              ctl_be,
  input  logic [ADDR_W-1:0] desc_ptr,
  input  logic              req_valid,
  input  logic [REQ_W-1:0]  req_bytes,
  output logic              busy,
  output logic              done,
  output logic              dev_clear,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [7:0]        dev_tx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [7:0]        dev_rx_data,
  output logic              dev_last
);
  localparam int FI_W = $clog2(DESC_BYTES);

  sgd_state_e          st;
  logic                h2d_q, be_q, eoc_q;
  logic [ADDR_W-1:0]   dptr, cur, nxt;
  logic [FI_W-1:0]     fidx;
  logic [CNT_W-1:0]    cnt;
  logic [REQ_W-1:0]    remain;
  logic [7:0]          data_q;
  logic [WORD_W-1:0]   d_buf, d_flags, d_link;
  logic [ADDR_W-1:0]   swz_addr;
  logic                chunk_last, start_ok, beat, fetch_beat;

  assign start_ok   = (st == S_IDLE) && req_valid && ctl_en && (req_bytes != '0);
  assign fetch_beat = (st == S_FETCH) && mem_req_ready;
  assign beat       = ((st == S_DTX) && dev_tx_ready) || ((st == S_MWR) && mem_req_ready);

  sgd_desc_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .shift_en(fetch_beat), .din(mem_rdata),
    .buf_word(d_buf), .flag_word(d_flags), .link_word(d_link)
  );

  sgd_lane_swz #(.ADDR_W(ADDR_W)) u_swz (
    .be(be_q), .addr_in(cur), .addr_out(swz_addr)
  );

  sgd_chunk_ctr #(.CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
    .clk(clk), .rst(rst), .clr(start_ok), .step(beat), .at_last(chunk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      h2d_q  <= 1'b0;
      be_q   <= 1'b0;
      eoc_q  <= 1'b0;
      dptr   <= '0;
      cur    <= '0;
      nxt    <= '0;
      fidx   <= '0;
      cnt    <= '0;
      remain <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_ok) begin
          h2d_q  <= ctl_h2d;
          be_q   <= ctl_be;
          dptr   <= desc_ptr;
          fidx   <= '0;
          remain <= req_bytes;
          st     <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) begin
          if (fidx == FI_W'(DESC_BYTES - 1)) st <= S_LOAD;
          else fidx <= fidx + 1'b1;
        end
        S_LOAD: begin
          cur   <= d_buf[ADDR_W-1:0];
          cnt   <= d_flags[CNT_W-1:0];
          eoc_q <= d_flags[EOC_BIT];
          nxt   <= d_link[ADDR_W-1:0];
          if (d_flags[CNT_W-1:0] == '0) begin
            if (d_flags[EOC_BIT]) st <= S_DONE;
            else begin
              dptr <= d_link[ADDR_W-1:0];
              fidx <= '0;
              st   <= S_FETCH;
            end
          end else begin
            st <= h2d_q ? S_MRD : S_DRX;
          end
        end
        S_MRD: if (mem_req_ready) begin
          data_q <= mem_rdata;
          st     <= S_DTX;
        end
        S_DRX: if (dev_rx_valid) begin
          data_q <= dev_rx_data;
          st     <= S_MWR;
        end
        S_DTX, S_MWR: if (beat) begin
          cur    <= cur + 1'b1;
          cnt    <= cnt - 1'b1;
          remain <= remain - 1'b1;
          if (remain == REQ_W'(1)) st <= S_DONE;
          else if (cnt == CNT_W'(1)) begin
            if (eoc_q) st <= S_DONE;
            else begin
              dptr <= nxt;
              fidx <= '0;
              st   <= S_FETCH;
            end
          end else begin
            st <= h2d_q ? S_MRD : S_DRX;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign done          = (st == S_DONE);
  assign dev_clear     = (st == S_DONE) && h2d_q;
  assign mem_req_valid = (st == S_FETCH) || (st == S_MRD) || (st == S_MWR);
  assign mem_req_we    = (st == S_MWR);
  assign mem_req_addr  = (st == S_FETCH) ? dptr + ADDR_W'(fidx) : swz_addr;
  assign mem_req_wdata = data_q;
  assign dev_tx_valid  = (st == S_DTX);
  assign dev_tx_data   = data_q;
  assign dev_rx_ready  = (st == S_DRX);
  assign dev_last      = ((st == S_DTX) || (st == S_DRX)) &&
                         (chunk_last || (remain == REQ_W'(1)) || ((cnt == CNT_W'(1)) && eoc_q));
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
  parameter int ADDR_W = 32,
  parameter int REQ_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_en,
  input logic              req_valid,
  input logic [REQ_W-1:0]  req_bytes,
  input logic              busy,
  input logic              done,
  input logic              dev_clear,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              dev_tx_valid,
  input logic              dev_tx_ready,
  input logic [7:0]        dev_tx_data,
  input logic              dev_rx_ready
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid && !dev_tx_valid && !dev_rx_ready && !done);

  assert_no_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && ctl_en && req_bytes != '0)) |=> !busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  assert_clear_with_done_R12: assert property (@(posedge clk) disable iff (rst)
    dev_clear |-> done);

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (dev_tx_valid && !dev_tx_ready) |=> dev_tx_valid && $stable(dev_tx_data));

  assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    !(dev_tx_valid && dev_rx_ready));
endmodule

bind sgdma_byte_mover sgd_checker #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_en(ctl_en), .req_valid(req_valid), .req_bytes(req_bytes),
  .busy(busy), .done(done), .dev_clear(dev_clear), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .dev_tx_valid(dev_tx_valid),
  .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data), .dev_rx_ready(dev_rx_ready)
);

// File: tb/sim_sgdma_byte_mover.sv
module sim_sgdma_byte_mover;
  localparam int CH   = 8;
  localparam int BASE = 32'h800;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_en = 0, ctl_h2d = 0, ctl_be = 0, req_valid = 0;
  logic [31:0] desc_ptr = '0;
  logic [15:0] req_bytes = '0;
  logic busy, done, dev_clear, mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [7:0] mem_req_wdata, mem_rdata, dev_tx_data, dev_rx_data;
  logic dev_tx_valid, dev_tx_ready, dev_rx_valid = 0, dev_rx_ready, dev_last;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tick = '0;
  logic [7:0] rx_idx = '0;
  logic [7:0] mem [0:4095];
  logic bw_en = 0;
  logic [11:0] bw_addr = '0;
  logic [7:0] bw_data = '0;

  logic [8:0]  exp_tx[$];
  logic [39:0] exp_wr[$];
  logic        exp_rxl[$];

  int d_addr[4], d_cnt[4];
  logic d_eoc[4];

  sgdma_byte_mover #(.CHUNK_BYTES(CH)) u0 (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_h2d(ctl_h2d), .ctl_be(ctl_be),
    .desc_ptr(desc_ptr), .req_valid(req_valid), .req_bytes(req_bytes),
    .busy(busy), .done(done), .dev_clear(dev_clear),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .dev_last(dev_last)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 5 + 7);
  endfunction

  assign mem_rdata     = mem[mem_req_addr[11:0]];
  assign mem_req_ready = (tick % 4) != 2;
  assign dev_tx_ready  = (tick % 3) != 1;
  assign dev_rx_data   = 8'(rx_idx * 7 + 3);

  always @(posedge clk) begin
    tick <= tick + 1'b1;
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
    end else if (bw_en) mem[bw_addr] <= bw_data;
    else if (mem_req_valid && mem_req_ready && mem_req_we) mem[mem_req_addr[11:0]] <= mem_req_wdata;
    if (dev_rx_valid && dev_rx_ready) rx_idx <= rx_idx + 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (!rst) begin
    if (dev_tx_valid && dev_tx_ready) begin
      if (exp_tx.size() == 0) chk(0, "R8 unexpected tx byte", dev_tx_data, 0);
      else begin
        logic [8:0] e;
        e = exp_tx.pop_front();
        chk(dev_tx_data == e[7:0], "R8/R7 tx data", dev_tx_data, e[7:0]);
        chk(dev_last == e[8], "R10 tx last", dev_last, e[8]);
      end
    end
    if (mem_req_valid && mem_req_ready && mem_req_we) begin
      if (exp_wr.size() == 0) chk(0, "R9 unexpected write", mem_req_addr, 0);
      else begin
        logic [39:0] w;
        w = exp_wr.pop_front();
        chk(mem_req_addr == w[39:8], "R9/R7 write addr", mem_req_addr, w[39:8]);
        chk(mem_req_wdata == w[7:0], "R9 write data", mem_req_wdata, w[7:0]);
      end
    end
    if (dev_rx_valid && dev_rx_ready) begin
      if (exp_rxl.size() == 0) chk(0, "R9 unexpected rx beat", 1, 0);
      else begin
        logic l;
        l = exp_rxl.pop_front();
        chk(dev_last == l, "R10 rx last", dev_last, l);
      end
    end
  end

  task automatic put_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    bw_en = 1; bw_addr = 12'(a); bw_data = d;
    @(negedge clk);
    bw_en = 0;
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) put_byte(a + b, w[31 - 8*b -: 8]);
  endtask

  task automatic build_chain(input int nd);
    for (int i = 0; i < nd; i++) begin
      put_word(BASE + 16*i, 32'(d_addr[i]));
      put_word(BASE + 16*i + 4, {d_eoc[i], 17'b0, 14'(d_cnt[i])});
      put_word(BASE + 16*i + 8, 32'(BASE + 16*(i+1)));
    end
  endtask

  task automatic run_xfer(input logic h2d, input logic be, input int nd, input int req, input string tag);
    int  n = 0;
    int  rem = req;
    logic fin = 0;
    int  adr[64];
    int  t = 0;
    logic [7:0] rbase;
    build_chain(nd);
    for (int i = 0; i < nd && !fin; i++) begin
      for (int k = 0; k < d_cnt[i] && !fin; k++) begin
        int a;
        a = d_addr[i] + k;
        adr[n] = be ? (a ^ 3) : a;
        n++; rem--;
        if (rem == 0) fin = 1;
      end
      if (d_eoc[i]) fin = 1;
    end
    rbase = rx_idx;
    for (int j = 0; j < n; j++) begin
      logic l;
      l = ((j % CH) == CH - 1) || (j == n - 1);
      if (h2d) exp_tx.push_back({l, pat(adr[j])});
      else begin
        exp_wr.push_back({32'(adr[j]), 8'(32'(rbase) + j) * 8'd7 + 8'd3});
        exp_rxl.push_back(l);
      end
    end
    @(negedge clk);
    ctl_en = 1; ctl_h2d = h2d; ctl_be = be; desc_ptr = BASE; req_bytes = 16'(req);
    req_valid = 1; dev_rx_valid = !h2d;
    @(negedge clk);
    req_valid = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, {tag, " R11 done seen"}, done, 1);
    chk(dev_clear == h2d, {tag, " R12 clear"}, dev_clear, h2d);
    @(negedge clk);
    chk(!busy && !done, {tag, " R11 idle after done"}, busy, 0);
    chk(exp_tx.size() == 0, {tag, " R8 tx left"}, exp_tx.size(), 0);
    chk(exp_wr.size() == 0, {tag, " R9 writes left"}, exp_wr.size(), 0);
    dev_rx_valid = 0;
    exp_tx.delete(); exp_wr.delete(); exp_rxl.delete();
  endtask

  task automatic quiet_req(input logic en, input int cnt, input string tag);
    logic seen = 0;
    @(negedge clk);
    ctl_en = en; ctl_h2d = 1; desc_ptr = BASE; req_bytes = 16'(cnt); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 12; i++) begin
      if (busy || mem_req_valid || done) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !dev_clear, "R1 status", {busy, done, dev_clear}, 0);
    chk(!mem_req_valid && !dev_tx_valid && !dev_rx_ready, "R1 handshakes",
        {mem_req_valid, dev_tx_valid, dev_rx_ready}, 0);
    // R2 ignored starts
    quiet_req(0, 10, "R2 disabled request");
    quiet_req(1, 0, "R2 zero-count request");
    // R3 R4 R8 little-endian single descriptor
    d_addr[0] = 'h100; d_cnt[0] = 10; d_eoc[0] = 1;
    run_xfer(1, 0, 1, 10, "R3 R4 LE h2d");
    // R5 R7 big-endian chain hop, R10 chunk mark across descriptors
    d_addr[0] = 'h120; d_cnt[0] = 5; d_eoc[0] = 0;
    d_addr[1] = 'h141; d_cnt[1] = 7; d_eoc[1] = 1;
    run_xfer(1, 1, 2, 12, "R5 R7 BE chain");
    // R6 early end of chain
    d_addr[0] = 'h160; d_cnt[0] = 4; d_eoc[0] = 1;
    run_xfer(1, 0, 1, 20, "R6 early end");
    // R9 device-to-host, big-endian, chained
    d_addr[0] = 'h400; d_cnt[0] = 3; d_eoc[0] = 0;
    d_addr[1] = 'h410; d_cnt[1] = 6; d_eoc[1] = 1;
    run_xfer(0, 1, 2, 9, "R9 d2h BE");
    // R10 request shorter than descriptor, several chunks
    d_addr[0] = 'h182; d_cnt[0] = 30; d_eoc[0] = 0;
    d_addr[1] = 'h200; d_cnt[1] = 4;  d_eoc[1] = 1;
    run_xfer(1, 0, 2, 20, "R10 multi chunk");
    // R9 device-to-host little-endian
    d_addr[0] = 'h423; d_cnt[0] = 5; d_eoc[0] = 1;
    run_xfer(0, 0, 1, 5, "R9 d2h LE");
    summary();
    $finish;
  end
endmodule